// File: doc/BRIEF.md
# March Algorithm Self-Test Sequencer

This block is a built-in self-test sequencer for a single-port, word-addressed RAM of `2**ADDR_W` words. When started, it drives the RAM through one of six March algorithms, picked by a 3-bit code. Each algorithm is a fixed list of elements. An element has an address direction and a short list of read and write operations. Every operation of an element is applied to one address before the next address is visited. The retention algorithm also holds two timed pauses between elements, during which the RAM is left untouched.

Every write stores a background word, which is either all zeros or all ones. Every read is checked against the background that the algorithm expects at that point. The RAM returns read data one cycle after the read is issued. The sequencer keeps a sticky fail flag, plus the address and element index of the first mismatch. When it finishes, it drops `busy` and holds `done` until the next accepted start.

Top module: `march_bist_engine`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `bad_sel`, `ram_we` and `ram_re` are all low.
- R2: When idle, a `start` with `alg_sel` 0 to 5 raises `busy` on the next cycle. From then on, exactly one RAM operation is issued per cycle, in this order. Code 0 is w0; up(r0,w1); down(r1,w0). Code 1 is the same, except its last element is down(r1,w0,r0). Code 2 is code 0 followed by up(r0). Code 3 is w0; up(r0,w1,r1); down(r1,w0,r0); up(r0). Code 4 is w0; up(r0,w1); up(r1,w0); down(r0,w1); down(r1,w0); up(r0). Code 5 is w0; up(r0,w1); up(r1,w0); down(r0,w1); down(r1,w0); pause; up(r0,w1); pause; up(r1).
- R3: Within an element, the address stays the same until all of that element's operations have been issued.
- R4: An ascending element visits addresses 0 up to 2**ADDR_W-1. A descending element visits them in the reverse order. An element with no required order runs ascending.
- R5: A write puts the same value on every bit of `ram_wdata`: all zeros for w0 and all ones for w1. `ram_we` and `ram_re` are never high together.
- R6: Read data is compared in the cycle after the read is issued. A mismatch sets `fail` and records `fail_addr` and `fail_elem` for the first mismatch only. `fail_elem` is the 0-based element position, and pauses count as elements. `fail` stays set until the next accepted start.
- R7: A pause lasts exactly `CLK_FREQ_HZ/1000*RETENTION_MS` cycles. During a pause `busy` stays high and neither `ram_we` nor `ram_re` is asserted.
- R8: `busy` falls and `done` rises on the same edge. `done` then stays high until the next accepted start, and it never overlaps `busy`.
- R9: A start with `alg_sel` 6 or 7 leaves the block idle with no RAM access, and raises `bad_sel` until the next accepted start.
- R10: A `start` that arrives while `busy` is high has no effect on the running sequence.
- R11: `busy` lasts for the total operation count times one cycle, plus the pause cycles, plus one final cycle for the last comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled while idle |
| alg_sel | input | 3 | Algorithm code |
| ram_rdata | input | DATA_W | RAM read data, valid one cycle after `ram_re` |
| ram_addr | output | ADDR_W | RAM word address |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_wdata | output | DATA_W | RAM write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |
| fail | output | 1 | At least one read mismatched |
| bad_sel | output | 1 | Last start carried an unsupported code |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 4 | Element index of the first mismatch |

## Verification
A wrong element, operation or address counter appears on the RAM strobes, the address or the write data in the very cycle it goes wrong, because each cycle carries exactly one operation. The bench compares every busy cycle against a behavioural operation list, so such an error is caught on the first cycle it occurs. A comparator that latches the wrong cycle, or that lets a later miss overwrite the first, shows up only at `done`. It is found there by injecting stuck bits whose first detecting element and address are known in advance.

// File: rtl/march_pkg.sv
package march_pkg;

  localparam int ALG_W  = 3;
  localparam int ELEM_W = 4;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_W0  = 3'd1,
    OP_W1  = 3'd2,
    OP_R0  = 3'd3,
    OP_R1  = 3'd4,
    OP_DLY = 3'd5
  } op_e;

  // ops[0] is issued first; len counts the valid slots
  typedef struct packed {
    logic           down;
    logic [1:0]     len;
    op_e  [2:0]     ops;
  } elem_t;

  localparam logic UP = 1'b0;
  localparam logic DN = 1'b1;

  function automatic elem_t mk(logic down, logic [1:0] len, op_e a, op_e b, op_e c);
    elem_t e;
    e.down   = down;
    e.len    = len;
    e.ops[0] = a;
    e.ops[1] = b;
    e.ops[2] = c;
    return e;
  endfunction

  function automatic logic alg_valid(logic [ALG_W-1:0] alg);
    return alg <= 3'd5;
  endfunction

  function automatic logic [ELEM_W-1:0] alg_elems(logic [ALG_W-1:0] alg);
    case (alg)
      3'd0, 3'd1: return 4'd3;
      3'd2, 3'd3: return 4'd4;
      3'd4:       return 4'd6;
      3'd5:       return 4'd9;
      default:    return 4'd0;
    endcase
  endfunction

  function automatic elem_t alg_elem(logic [ALG_W-1:0] alg, logic [ELEM_W-1:0] e);
    elem_t r;
    r = mk(UP, 2'd1, OP_NOP, OP_NOP, OP_NOP);
    if (e == 4'd0) begin
      if (alg_valid(alg)) r = mk(UP, 2'd1, OP_W0, OP_NOP, OP_NOP);
    end else begin
      case (alg)
        3'd0, 3'd1, 3'd2: begin
          case (e)
            4'd1: r = mk(UP, 2'd2, OP_R0, OP_W1, OP_NOP);
            4'd2: r = (alg == 3'd1) ? mk(DN, 2'd3, OP_R1, OP_W0, OP_R0)
                                    : mk(DN, 2'd2, OP_R1, OP_W0, OP_NOP);
            4'd3: r = mk(UP, 2'd1, OP_R0, OP_NOP, OP_NOP);
            default: ;
          endcase
        end
        3'd3: begin
          case (e)
            4'd1: r = mk(UP, 2'd3, OP_R0, OP_W1, OP_R1);
            4'd2: r = mk(DN, 2'd3, OP_R1, OP_W0, OP_R0);
            4'd3: r = mk(UP, 2'd1, OP_R0, OP_NOP, OP_NOP);
            default: ;
          endcase
        end
        3'd4, 3'd5: begin
          case (e)
            4'd1: r = mk(UP, 2'd2, OP_R0, OP_W1, OP_NOP);
            4'd2: r = mk(UP, 2'd2, OP_R1, OP_W0, OP_NOP);
            4'd3: r = mk(DN, 2'd2, OP_R0, OP_W1, OP_NOP);
            4'd4: r = mk(DN, 2'd2, OP_R1, OP_W0, OP_NOP);
            4'd5: r = (alg == 3'd4) ? mk(UP, 2'd1, OP_R0, OP_NOP, OP_NOP)
                                    : mk(UP, 2'd1, OP_DLY, OP_NOP, OP_NOP);
            4'd6: r = mk(UP, 2'd2, OP_R0, OP_W1, OP_NOP);
            4'd7: r = mk(UP, 2'd1, OP_DLY, OP_NOP, OP_NOP);
            4'd8: r = mk(UP, 2'd1, OP_R1, OP_NOP, OP_NOP);
            default: ;
          endcase
        end
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic logic op_is_read(op_e op);
    return (op == OP_R0) || (op == OP_R1);
  endfunction

  function automatic logic op_is_write(op_e op);
    return (op == OP_W0) || (op == OP_W1);
  endfunction

  function automatic logic op_bg(op_e op);
    return (op == OP_W1) || (op == OP_R1);
  endfunction

endpackage

// File: rtl/march_prog_rom.sv
module march_prog_rom
  import march_pkg::*;
(
  input  logic [ALG_W-1:0]  alg,
  input  logic [ELEM_W-1:0] elem,
  input  logic [1:0]        op_idx,
  output op_e               op,
  output logic              down,
  output logic              op_last,
  output logic              elem_last,
  output logic              is_delay
);
  elem_t info;

  always_comb begin
    info      = alg_elem(alg, elem);
    op        = info.ops[op_idx];
    down      = info.down;
    op_last   = (op_idx == info.len - 2'd1);
    elem_last = (elem == alg_elems(alg) - 4'd1);
    is_delay  = (info.ops[0] == OP_DLY);
  end
endmodule

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_down,
  input  logic              step,
  input  logic              down,
  output logic [ADDR_W-1:0] addr,
  output logic              at_end
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_down ? TOP_ADDR : '0;
    else if (step) addr <= down ? addr - 1'b1 : addr + 1'b1;
  end

  assign at_end = down ? (addr == '0) : (addr == TOP_ADDR);
endmodule

// File: rtl/march_read_cmp.sv
module march_read_cmp
  import march_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              issue_rd,
  input  logic              exp_bit,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ELEM_W-1:0] rd_elem,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              cmp_miss,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ELEM_W-1:0] fail_elem
);
  logic              pend_v;
  logic              pend_exp;
  logic [ADDR_W-1:0] pend_addr;
  logic [ELEM_W-1:0] pend_elem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_exp  <= 1'b0;
      pend_addr <= '0;
      pend_elem <= '0;
    end else begin
      pend_v <= issue_rd && !clear;
      if (issue_rd) begin
        pend_exp  <= exp_bit;
        pend_addr <= rd_addr;
        pend_elem <= rd_elem;
      end
    end
  end

  assign cmp_miss = pend_v && (ram_rdata != {DATA_W{pend_exp}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_elem <= '0;
    end else if (clear) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_elem <= '0;
    end else if (cmp_miss && !fail) begin
      fail      <= 1'b1;
      fail_addr <= pend_addr;
      fail_elem <= pend_elem;
    end
  end
endmodule

// File: rtl/march_bist_engine.sv
module march_bist_engine
  import march_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int CLK_FREQ_HZ  = 50_000_000,
  parameter int RETENTION_MS = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        alg_sel,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic              ram_re,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              bad_sel,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [3:0]        fail_elem
);
  localparam int DELAY_CYCLES = (CLK_FREQ_HZ / 1000) * RETENTION_MS;
  localparam int DLY_W        = $clog2(DELAY_CYCLES + 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(DELAY_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT, ST_DRAIN} state_e;

  state_e            state;
  logic [ALG_W-1:0]  alg_q;
  logic [ELEM_W-1:0] elem_q;
  logic [1:0]        op_q;
  logic [DLY_W-1:0]  dly_cnt;
  logic              done_q, bad_q;

  op_e               cur_op;
  logic              cur_down, op_last, elem_last, cur_delay;
  logic              at_end;
  logic [ALG_W-1:0]  alg_nx;
  logic [ELEM_W-1:0] elem_nx;
  elem_t             nxt_info;

  // named events used by the bound checker
  logic start_ok, start_bad, run_op, op_mid, addr_step, elem_adv, seq_end;

  march_prog_rom i_rom (
    .alg(alg_q), .elem(elem_q), .op_idx(op_q), .op(cur_op), .down(cur_down),
    .op_last(op_last), .elem_last(elem_last), .is_delay(cur_delay)
  );

  always_comb begin
    alg_nx   = (state == ST_IDLE) ? alg_sel : alg_q;
    elem_nx  = (state == ST_IDLE) ? '0 : elem_q + 4'd1;
    nxt_info = alg_elem(alg_nx, elem_nx);
  end

  assign start_ok  = (state == ST_IDLE) && start && alg_valid(alg_sel);
  assign start_bad = (state == ST_IDLE) && start && !alg_valid(alg_sel);
  assign run_op    = (state == ST_RUN) && !cur_delay;
  assign op_mid    = run_op && !op_last;
  assign addr_step = run_op && op_last && !at_end;
  assign elem_adv  = (run_op && op_last && at_end) ||
                     ((state == ST_WAIT) && (dly_cnt == DLY_LAST));
  assign seq_end   = elem_adv && elem_last;

  march_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
    .clk(clk), .rst_n(rst_n),
    .load(start_ok || (elem_adv && !elem_last)), .load_down(nxt_info.down),
    .step(addr_step), .down(cur_down), .addr(ram_addr), .at_end(at_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      alg_q   <= '0;
      elem_q  <= '0;
      op_q    <= '0;
      dly_cnt <= '0;
      done_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_ok) begin
            state  <= ST_RUN;
            alg_q  <= alg_sel;
            elem_q <= '0;
            op_q   <= '0;
            done_q <= 1'b0;
            bad_q  <= 1'b0;
          end else if (start_bad) begin
            bad_q <= 1'b1;
          end
        end
        ST_RUN, ST_WAIT: begin
          if (state == ST_WAIT) dly_cnt <= dly_cnt + 1'b1;
          if (seq_end) begin
            state <= ST_DRAIN;
          end else if (elem_adv) begin
            elem_q  <= elem_nx;
            op_q    <= '0;
            dly_cnt <= '0;
            state   <= (nxt_info.ops[0] == OP_DLY) ? ST_WAIT : ST_RUN;
          end else if (state == ST_RUN) begin
            op_q <= op_last ? 2'd0 : op_q + 2'd1;
          end
        end
        default: begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
        end
      endcase
    end
  end

  assign ram_we    = run_op && op_is_write(cur_op);
  assign ram_re    = run_op && op_is_read(cur_op);
  assign ram_wdata = {DATA_W{op_bg(cur_op)}};
  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign bad_sel   = bad_q;

  march_read_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cmp (
    .clk(clk), .rst_n(rst_n), .clear(start_ok), .issue_rd(ram_re),
    .exp_bit(op_bg(cur_op)), .rd_addr(ram_addr), .rd_elem(elem_q),
    .ram_rdata(ram_rdata), .cmp_miss(), .fail(fail),
    .fail_addr(fail_addr), .fail_elem(fail_elem)
  );
endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [2:0]        alg_sel,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_we,
  input logic              ram_re,
  input logic [DATA_W-1:0] ram_wdata,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              bad_sel,
  input logic              op_mid
);
  // R5
  bg_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_wdata == '0 || ram_wdata == '1));
  // R5
  no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));
  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R8
  busy_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && alg_sel <= 3'd5) |=> busy);
  // R9
  bad_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && alg_sel > 3'd5) |=> (!busy && bad_sel && !ram_we && !ram_re));
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_mid |=> $stable(ram_addr));
  // R6
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);
endmodule

bind march_bist_engine march_bist_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel),
  .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re), .ram_wdata(ram_wdata),
  .busy(busy), .done(done), .fail(fail), .bad_sel(bad_sel), .op_mid(op_mid)
);

// File: tb/test_march_bist_engine.sv
module test_march_bist_engine;
  localparam int AW = 3;
  localparam int DW = 4;
  localparam int N  = 1 << AW;
  localparam int DLY = 8;  // 8000 Hz / 1000 * 1 ms

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] alg_sel = '0;
  logic [DW-1:0] ram_rdata;
  logic [AW-1:0] ram_addr, fail_addr;
  logic ram_we, ram_re, busy, done, fail, bad_sel;
  logic [DW-1:0] ram_wdata;
  logic [3:0] fail_elem;

  always #10 clk = ~clk;

  march_bist_engine #(.ADDR_W(AW), .DATA_W(DW), .CLK_FREQ_HZ(8000), .RETENTION_MS(1)) i_march_bist_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel), .ram_rdata(ram_rdata),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re), .ram_wdata(ram_wdata),
    .busy(busy), .done(done), .fail(fail), .bad_sel(bad_sel),
    .fail_addr(fail_addr), .fail_elem(fail_elem)
  );

  // RAM with one-cycle read latency and an optional stuck bit on reads
  logic [DW-1:0] mem [N];
  bit flt_en = 0; int flt_addr = 0; int flt_bit = 0; bit flt_val = 0;
  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) begin
      logic [DW-1:0] v;
      v = mem[ram_addr];
      if (flt_en && int'(ram_addr) == flt_addr) v[flt_bit] = flt_val;
      ram_rdata <= v;
    end
  end

  int errs = 0, checks = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  typedef struct { int kind; int addr; int elem; } ent_t; // kind 0 pause,1 w0,2 w1,3 r0,4 r1
  ent_t q[$];

  function automatic int n_elems(int alg);
    case (alg) 0, 1: return 3; 2, 3: return 4; 4: return 6; default: return 9; endcase
  endfunction

  function automatic string spec(int alg, int e);
    string c4[6] = '{"Uw0", "Ur0w1", "Ur1w0", "Dr0w1", "Dr1w0", "Ur0"};
    string c5[9] = '{"Uw0", "Ur0w1", "Ur1w0", "Dr0w1", "Dr1w0", "T", "Ur0w1", "T", "Ur1"};
    string y[4]  = '{"Uw0", "Ur0w1r1", "Dr1w0r0", "Ur0"};
    case (alg)
      0: return (e == 0) ? "Uw0" : (e == 1) ? "Ur0w1" : "Dr1w0";
      1: return (e == 0) ? "Uw0" : (e == 1) ? "Ur0w1" : "Dr1w0r0";
      2: return (e == 0) ? "Uw0" : (e == 1) ? "Ur0w1" : (e == 2) ? "Dr1w0" : "Ur0";
      3: return y[e];
      4: return c4[e];
      default: return c5[e];
    endcase
  endfunction

  task automatic build(int alg);
    q.delete();
    for (int e = 0; e < n_elems(alg); e++) begin
      string s = spec(alg, e);
      if (s.substr(0, 0) == "T") begin
        for (int c = 0; c < DLY; c++) q.push_back('{0, 0, e});
      end else begin
        for (int i = 0; i < N; i++) begin
          int a = (s.substr(0, 0) == "D") ? N - 1 - i : i;
          for (int p = 1; p < s.len(); p += 2) begin
            int k = (s.substr(p, p) == "w") ? 1 : 3;
            if (s.substr(p + 1, p + 1) == "1") k++;
            q.push_back('{k, a, e});
          end
        end
      end
    end
  endtask

  task automatic run(int alg, int poke_at);
    int xf = 0, xa = 0, xe = 0;
    build(alg);
    foreach (q[i]) if (xf == 0 && flt_en && q[i].kind >= 3 && q[i].addr == flt_addr &&
                       int'(flt_val) != q[i].kind - 3) begin
      xf = 1; xa = q[i].addr; xe = q[i].elem;
    end
    @(negedge clk); alg_sel = 3'(alg); start = 1'b1;
    @(negedge clk); start = 1'b0;
    foreach (q[i]) begin
      bit ew = (q[i].kind == 1 || q[i].kind == 2);
      bit er = (q[i].kind >= 3);
      if (i == poke_at) begin start = 1'b1; alg_sel = 3'd0; end  // R10 ignored
      chk(busy, "R2", "busy during run", int'(busy), 1);
      chk(ram_we == ew, q[i].kind == 0 ? "R7" : "R2", "write strobe", int'(ram_we), int'(ew));
      chk(ram_re == er, q[i].kind == 0 ? "R7" : "R2", "read strobe", int'(ram_re), int'(er));
      if (ew || er) chk(int'(ram_addr) == q[i].addr, "R4", "address", int'(ram_addr), q[i].addr);
      if (ew) chk(ram_wdata == {DW{q[i].kind == 2}}, "R5", "write data", int'(ram_wdata),
                  (q[i].kind == 2) ? (1 << DW) - 1 : 0);
      @(negedge clk); start = 1'b0;
    end
    chk(busy && !done, "R11", "final compare cycle", int'(busy), 1);
    @(negedge clk);
    chk(!busy && done, "R8", "done after sequence", int'(done), 1);
    chk(fail == xf[0], "R6", "fail flag", int'(fail), xf);
    if (xf != 0) begin
      chk(int'(fail_addr) == xa, "R6", "first fail address", int'(fail_addr), xa);
      chk(int'(fail_elem) == xe, "R6", "first fail element", int'(fail_elem), xe);
    end
    repeat (3) @(negedge clk);
    chk(done && !busy, "R8", "done held", int'(done), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !bad_sel && !ram_we && !ram_re, "R1", "reset state",
        int'({busy, done, fail, bad_sel, ram_we, ram_re}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 6; c < 8; c++) begin  // R9
      alg_sel = 3'(c); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(!busy && bad_sel && !ram_we && !ram_re, "R9", "unsupported code", int'(busy), 0);
      @(negedge clk);
      chk(!busy && !ram_we && !ram_re, "R9", "stays idle", int'(busy), 0);
    end
    for (int a = 0; a < 6; a++) begin
      run(a, (a == 3) ? 10 : -1);
      chk(!bad_sel, "R9", "bad_sel cleared by valid start", int'(bad_sel), 0);
    end
    flt_en = 1; flt_addr = 5; flt_bit = 2; flt_val = 0; run(0, -1);
    flt_addr = 3; flt_bit = 0; flt_val = 1; run(4, -1);
    flt_addr = N - 1; flt_bit = 3; flt_val = 0; run(5, -1);
    flt_addr = 0; flt_bit = 1; flt_val = 1; run(3, -1);
    flt_en = 0; run(1, -1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule